// File: doc/BRIEF.md
# Delayed Register Write-Back Queue

This block holds register updates that must land a set number of ticks after they are issued. A producer pushes an entry naming a destination register, a countdown, a data value, an operand width (32 or 64 bits) and, optionally, a bit position. Each pulse on the tick input counts down every waiting entry. When an entry's countdown runs out, the queue sends it through a single register-file write port. The update is either a whole-register write or a set or clear of one bit.

Entries sit in a ring of eight slots. Entries can finish counting out of order. A slot only returns to the free pool when it is the oldest occupied slot and its write has already been issued. When several entries finish on the same tick, their writes leave one per cycle, oldest first. The producer sees a full flag when all slots are taken. An error output flags an impossible pointer state.

Top module: `delayed_wb_queue`

## Requirements
- R1: A synchronous active-high reset empties the queue, drops every pending entry, deasserts `enq_full`, `wr_en` and `err`, and no dropped entry is written afterwards.
- R2: While `enq_full` is low, a cycle with `enq_valid` high stores one entry. The queue holds up to 8 entries.
- R3: `enq_full` is high exactly when 8 entries are held. An entry offered while full is discarded and never appears on the write port.
- R4: A cycle with `tick` high counts down every waiting entry by one. An entry loaded with delay D≥1 finishes on its D-th tick, and a delay of 0 acts as 1. `wr_en` for that entry is high in the cycle after the clock edge that samples the finishing tick, and not before.
- R5: With the bit-update flag clear, the write is a full write (`wr_mode` = 0) carrying the stored value. For a 32-bit entry (`enq_wide` = 0) the upper 32 bits of `wr_data` are zero.
- R6: With the bit-update flag set, `wr_data` is a one-hot mask at the bit index. The index is taken modulo 32 for a 32-bit entry. `wr_mode` is 1 (set) when the value, narrowed to the entry's width, is nonzero, and 2 (clear) when it is zero.
- R7: Entries that finish on the same tick are written on consecutive cycles, one per cycle, in ring order starting from the oldest entry.
- R8: A slot is released only when it is the oldest entry and its write has been issued. Younger entries that finish early keep `enq_full` high until the oldest one is written.
- R9: `err` is high when the insert and remove pointers differ while the entry count is zero. In correct operation it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Countdown strobe |
| enq_valid | input | 1 | Offer a new entry |
| enq_idx | input | 5 | Destination register index |
| enq_delay | input | 8 | Ticks before the update is applied |
| enq_value | input | 64 | Update value |
| enq_wide | input | 1 | 1: 64-bit destination, 0: 32-bit destination |
| enq_bit_en | input | 1 | 1: single-bit update, 0: full write |
| enq_bit | input | 6 | Bit position for a single-bit update |
| enq_full | output | 1 | All slots occupied; offers are refused |
| wr_en | output | 1 | Write-port strobe |
| wr_idx | output | 5 | Write-port register index |
| wr_wide | output | 1 | Write-port width (1 = 64-bit) |
| wr_mode | output | 2 | 0 full write, 1 set bit, 2 clear bit |
| wr_data | output | 64 | Full value, or one-hot bit mask |
| err | output | 1 | Pointer and count disagree |

## Verification
The bound checker checks these on every cycle: the entry count never exceeds the slot count, the error flag stays low, and the remove pointer moves by at most one slot per cycle. It also checks that a refused offer leaves the insert pointer unchanged, and that every write strobe carries a legal mode, a one-hot mask for bit updates, and clean upper bits for 32-bit entries. Only the bench's scenarios can show the exact cycle a countdown finishes, the order of writes when several entries finish together after the ring has wrapped, the full flag held by a slow oldest entry, and the loss of pending entries at reset.

// File: rtl/dwbq_pkg.sv
package dwbq_pkg;
   typedef enum logic [1:0] {
      S_EMPTY = 2'd0,
      S_WAIT  = 2'd1,
      S_READY = 2'd2,
      S_SPENT = 2'd3
   } slot_st_e;

   typedef enum logic [1:0] {
      WM_FULL = 2'd0,
      WM_SET  = 2'd1,
      WM_CLR  = 2'd2
   } wr_mode_e;
endpackage

// File: rtl/dwbq_slot.sv
// One ring slot: holds an entry, counts it down, tracks issue and release.
module dwbq_slot
   import dwbq_pkg::*;
#(
   parameter int IDX_W  = 5,
   parameter int DLY_W  = 8,
   parameter int WIDE_W = 64,
   parameter int BIT_W  = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [DLY_W-1:0]  ld_dly,
   input  logic [WIDE_W-1:0] ld_val,
   input  logic              ld_wide,
   input  logic              ld_biten,
   input  logic [BIT_W-1:0]  ld_bit,
   input  logic              tick,
   input  logic              take,
   input  logic              drop,
   output slot_st_e          st,
   output logic [IDX_W-1:0]  idx,
   output logic [WIDE_W-1:0] val,
   output logic              wide,
   output logic              biten,
   output logic [BIT_W-1:0]  bit_no
);
   logic [DLY_W-1:0] dly;

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= S_EMPTY;
         dly    <= '0;
         idx    <= '0;
         val    <= '0;
         wide   <= 1'b0;
         biten  <= 1'b0;
         bit_no <= '0;
      end else if (ld) begin
         st     <= S_WAIT;
         dly    <= ld_dly;
         idx    <= ld_idx;
         val    <= ld_val;
         wide   <= ld_wide;
         biten  <= ld_biten;
         bit_no <= ld_bit;
      end else begin
         unique case (st)
            S_WAIT: if (tick) begin
               if (dly <= DLY_W'(1)) begin
                  st  <= S_READY;
                  dly <= '0;
               end else begin
                  dly <= dly - DLY_W'(1);
               end
            end
            S_READY: if (take) st <= S_SPENT;
            S_SPENT: if (drop) st <= S_EMPTY;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dwbq_pick.sv
// Rotating priority picker: lowest set request at or after base, ring order.
module dwbq_pick #(
   parameter int N  = 8,
   parameter int PW = 3
) (
   input  logic [N-1:0]  req,
   input  logic [PW-1:0] base,
   output logic          hit,
   output logic [PW-1:0] sel
);
   logic [2*N-1:0] dbl;
   logic [N-1:0]   rot;
   logic [PW-1:0]  off;

   always_comb begin
      dbl = {req, req} >> base;
      rot = dbl[N-1:0];
      off = '0;
      hit = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (rot[i]) begin
            off = PW'(i);
            hit = 1'b1;
         end
      end
      sel = base + off;
   end
endmodule

// File: rtl/delayed_wb_queue.sv
module delayed_wb_queue
   import dwbq_pkg::*;
#(
   parameter int NSLOT    = 8,
   parameter int IDX_W    = 5,
   parameter int DLY_W    = 8,
   parameter int WIDE_W   = 64,
   parameter int NARROW_W = 32
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       tick,
   input  logic                       enq_valid,
   input  logic [IDX_W-1:0]           enq_idx,
   input  logic [DLY_W-1:0]           enq_delay,
   input  logic [WIDE_W-1:0]          enq_value,
   input  logic                       enq_wide,
   input  logic                       enq_bit_en,
   input  logic [$clog2(WIDE_W)-1:0]  enq_bit,
   output logic                       enq_full,
   output logic                       wr_en,
   output logic [IDX_W-1:0]           wr_idx,
   output logic                       wr_wide,
   output logic [1:0]                 wr_mode,
   output logic [WIDE_W-1:0]          wr_data,
   output logic                       err
);
   localparam int BIT_W = $clog2(WIDE_W);
   localparam int PTR_W = $clog2(NSLOT);
   localparam int CNT_W = $clog2(NSLOT + 1);
   localparam logic [WIDE_W-1:0] NARROW_MASK = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
   localparam logic [BIT_W-1:0]  NBIT_MASK   = BIT_W'(NARROW_W - 1);

   if (NSLOT < 2 || (NSLOT & (NSLOT - 1)) != 0) begin : g_bad_nslot
      $error("NSLOT must be a power of two, at least 2");
   end
   if (NARROW_W >= WIDE_W || (NARROW_W & (NARROW_W - 1)) != 0) begin : g_bad_width
      $error("NARROW_W must be a power of two below WIDE_W");
   end

   logic [PTR_W-1:0] wptr, rptr;
   logic [CNT_W-1:0] count;
   logic             accept, free_head, hit;
   logic [PTR_W-1:0] sel;
   logic [NSLOT-1:0] ready;

   slot_st_e          s_st    [NSLOT];
   logic [IDX_W-1:0]  s_idx   [NSLOT];
   logic [WIDE_W-1:0] s_val   [NSLOT];
   logic              s_wide  [NSLOT];
   logic              s_biten [NSLOT];
   logic [BIT_W-1:0]  s_bit   [NSLOT];

   assign enq_full  = (count == CNT_W'(NSLOT));
   assign accept    = enq_valid && !enq_full;
   assign free_head = (s_st[rptr] == S_SPENT);
   assign err       = (wptr != rptr) && (count == '0);

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      assign ready[k] = (s_st[k] == S_READY);
      dwbq_slot #(
         .IDX_W(IDX_W), .DLY_W(DLY_W), .WIDE_W(WIDE_W), .BIT_W(BIT_W)
      ) u_slot (
         .clk     (clk),
         .rst     (rst),
         .ld      (accept && (wptr == PTR_W'(k))),
         .ld_idx  (enq_idx),
         .ld_dly  (enq_delay),
         .ld_val  (enq_value),
         .ld_wide (enq_wide),
         .ld_biten(enq_bit_en),
         .ld_bit  (enq_bit),
         .tick    (tick),
         .take    (hit && (sel == PTR_W'(k))),
         .drop    (free_head && (rptr == PTR_W'(k))),
         .st      (s_st[k]),
         .idx     (s_idx[k]),
         .val     (s_val[k]),
         .wide    (s_wide[k]),
         .biten   (s_biten[k]),
         .bit_no  (s_bit[k])
      );
   end

   dwbq_pick #(.N(NSLOT), .PW(PTR_W)) u_pick (
      .req (ready),
      .base(rptr),
      .hit (hit),
      .sel (sel)
   );

   // Shape the selected entry for the write port.
   logic [WIDE_W-1:0] n_val, n_mask;
   logic [BIT_W-1:0]  n_bit;
   wr_mode_e          n_mode;

   always_comb begin
      n_val  = s_wide[sel] ? s_val[sel] : (s_val[sel] & NARROW_MASK);
      n_bit  = s_wide[sel] ? s_bit[sel] : (s_bit[sel] & NBIT_MASK);
      n_mask = WIDE_W'(1) << n_bit;
      if (!s_biten[sel])    n_mode = WM_FULL;
      else if (n_val != '0) n_mode = WM_SET;
      else                  n_mode = WM_CLR;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr    <= '0;
         rptr    <= '0;
         count   <= '0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_wide <= 1'b0;
         wr_mode <= WM_FULL;
         wr_data <= '0;
      end else begin
         if (accept)    wptr <= wptr + PTR_W'(1);
         if (free_head) rptr <= rptr + PTR_W'(1);
         count <= count + CNT_W'(accept) - CNT_W'(free_head);
         wr_en <= hit;
         if (hit) begin
            wr_idx  <= s_idx[sel];
            wr_wide <= s_wide[sel];
            wr_mode <= n_mode;
            wr_data <= s_biten[sel] ? n_mask : n_val;
         end
      end
   end
endmodule

// File: rtl/dwbq_chk.sv
module dwbq_chk #(
   parameter int NSLOT  = 8,
   parameter int PTR_W  = 3,
   parameter int CNT_W  = 4,
   parameter int WIDE_W = 64,
   parameter int NARROW_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              enq_valid,
   input logic              enq_full,
   input logic [PTR_W-1:0]  wptr,
   input logic [PTR_W-1:0]  rptr,
   input logic [CNT_W-1:0]  count,
   input logic              wr_en,
   input logic              wr_wide,
   input logic [1:0]        wr_mode,
   input logic [WIDE_W-1:0] wr_data,
   input logic              err
);
   p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
      count <= CNT_W'(NSLOT));

   p_refused_offer_r3: assert property (@(posedge clk) disable iff (rst)
      (enq_valid && enq_full) |=> $stable(wptr));

   p_mode_legal_r5: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (wr_mode != 2'd3));

   p_narrow_clean_r5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_wide) |-> (wr_data[WIDE_W-1:NARROW_W] == '0));

   p_bit_mask_onehot_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_mode != 2'd0) |-> $onehot(wr_data));

   p_release_step_r8: assert property (@(posedge clk) disable iff (rst)
      ##1 (rptr == $past(rptr) || rptr == $past(rptr) + PTR_W'(1)));

   p_no_error_r9: assert property (@(posedge clk) disable iff (rst)
      !err);
endmodule

bind delayed_wb_queue dwbq_chk #(
   .NSLOT(NSLOT), .PTR_W(PTR_W), .CNT_W(CNT_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .enq_valid(enq_valid),
   .enq_full (enq_full),
   .wptr     (wptr),
   .rptr     (rptr),
   .count    (count),
   .wr_en    (wr_en),
   .wr_wide  (wr_wide),
   .wr_mode  (wr_mode),
   .wr_data  (wr_data),
   .err      (err)
);

// File: tb/delayed_wb_queue_tb.sv
module delayed_wb_queue_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick = 1'b0;
   logic        enq_valid = 1'b0;
   logic [4:0]  enq_idx = '0;
   logic [7:0]  enq_delay = '0;
   logic [63:0] enq_value = '0;
   logic        enq_wide = 1'b0;
   logic        enq_bit_en = 1'b0;
   logic [5:0]  enq_bit = '0;
   logic        enq_full, wr_en, wr_wide, err;
   logic [4:0]  wr_idx;
   logic [1:0]  wr_mode;
   logic [63:0] wr_data;

   int checks = 0, fails = 0;
   int err_seen = 0, stray_seen = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   delayed_wb_queue u_dut (
      .clk(clk), .rst(rst), .tick(tick), .enq_valid(enq_valid),
      .enq_idx(enq_idx), .enq_delay(enq_delay), .enq_value(enq_value),
      .enq_wide(enq_wide), .enq_bit_en(enq_bit_en), .enq_bit(enq_bit),
      .enq_full(enq_full), .wr_en(wr_en), .wr_idx(wr_idx), .wr_wide(wr_wide),
      .wr_mode(wr_mode), .wr_data(wr_data), .err(err)
   );

   typedef struct packed {
      logic [4:0]  idx;
      logic [7:0]  dly;
      logic [63:0] val;
      logic        wide;
      logic        biten;
      logic [5:0]  bitn;
      logic [1:0]  mode;
      logic [63:0] data;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      // R5 wide full write
      '{5'd3,  8'd1, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, 6'd0,  2'd0, 64'h0123_4567_89AB_CDEF},
      // R5 narrow full write drops upper half
      '{5'd7,  8'd4, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 6'd0,  2'd0, 64'h0000_0000_89AB_CDEF},
      // R6 wide set of bit 40
      '{5'd1,  8'd2, 64'd5,                   1'b1, 1'b1, 6'd40, 2'd1, 64'h0000_0100_0000_0000},
      // R6 wide clear of bit 63
      '{5'd2,  8'd3, 64'd0,                   1'b1, 1'b1, 6'd63, 2'd2, 64'h8000_0000_0000_0000},
      // R6 narrow set, index 45 wraps to 13; R4 delay 0 acts as 1
      '{5'd4,  8'd0, 64'd1,                   1'b0, 1'b1, 6'd45, 2'd1, 64'h0000_0000_0000_2000},
      // R6 narrow clear: value nonzero only above bit 31
      '{5'd31, 8'd5, 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, 6'd7,  2'd2, 64'h0000_0000_0000_0080},
      // R5 narrow full write
      '{5'd0,  8'd2, 64'hDEAD_BEEF_CAFE_F00D, 1'b0, 1'b0, 6'd0,  2'd0, 64'h0000_0000_CAFE_F00D}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic enq(input logic [4:0] i, input logic [7:0] d, input logic [63:0] v,
                      input logic w, input logic be, input logic [5:0] b);
      enq_valid = 1'b1; enq_idx = i; enq_delay = d; enq_value = v;
      enq_wide = w; enq_bit_en = be; enq_bit = b;
      @(negedge clk);
      enq_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (!rst && err) err_seen++;
      if (!rst && wr_en && wr_idx == 5'd30) stray_seen++;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      chk(!enq_full && !wr_en && !err, "R1", "reset outputs",
          {61'd0, enq_full, wr_en, err}, 64'd0);

      // Table walk: R4 timing, R5/R6 write shaping
      for (int n = 0; n < NV; n++) begin
         int ticks;
         bit early;
         ticks = (VECS[n].dly == 0) ? 1 : int'(VECS[n].dly);
         enq(VECS[n].idx, VECS[n].dly, VECS[n].val, VECS[n].wide, VECS[n].biten, VECS[n].bitn);
         early = 1'b0;
         tick = 1'b1;
         for (int t = 0; t < ticks; t++) begin
            if (wr_en) early = 1'b1;
            @(negedge clk);
         end
         tick = 1'b0;
         if (wr_en) early = 1'b1;
         chk(!early, "R4", "no write before countdown ends", {63'd0, early}, 64'd0);
         @(negedge clk);
         chk(wr_en, "R4", "write strobe after final tick", {63'd0, wr_en}, 64'd1);
         chk(wr_idx == VECS[n].idx && wr_wide == VECS[n].wide, VECS[n].biten ? "R6" : "R5",
             "index/width", {57'd0, wr_wide, 1'b0, wr_idx}, {57'd0, VECS[n].wide, 1'b0, VECS[n].idx});
         chk(wr_mode == VECS[n].mode, VECS[n].biten ? "R6" : "R5", "mode",
             {62'd0, wr_mode}, {62'd0, VECS[n].mode});
         chk(wr_data == VECS[n].data, VECS[n].biten ? "R6" : "R5", "data", wr_data, VECS[n].data);
         @(negedge clk);
         chk(!wr_en, "R4", "single write pulse", {63'd0, wr_en}, 64'd0);
         repeat (2) @(negedge clk);
      end

      // R2/R3: fill all 8 slots (ring pointers are mid-ring here), oldest is slow
      enq(5'd8, 8'd3, 64'd8, 1'b1, 1'b0, 6'd0);
      for (int k = 1; k < 8; k++) begin
         chk(!enq_full, "R2", "not full while filling", {63'd0, enq_full}, 64'd0);
         enq(5'(8 + k), 8'd1, 64'(k), 1'b1, 1'b0, 6'd0);
      end
      chk(enq_full, "R3", "full with 8 entries", {63'd0, enq_full}, 64'd1);
      enq(5'd30, 8'd1, 64'd30, 1'b1, 1'b0, 6'd0);   // R3 refused offer

      // R7: seven entries finish on one tick, written oldest first
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      chk(!wr_en, "R7", "no write in ready cycle", {63'd0, wr_en}, 64'd0);
      for (int j = 0; j < 7; j++) begin
         @(negedge clk);
         chk(wr_en && wr_idx == 5'(9 + j), "R7", "ring-ordered write",
             {58'd0, wr_en, wr_idx}, {58'd1, 5'(9 + j)});
         chk(enq_full, "R8", "full held by unfinished oldest", {63'd0, enq_full}, 64'd1);
      end
      @(negedge clk);
      chk(!wr_en, "R7", "burst ends", {63'd0, wr_en}, 64'd0);
      tick = 1'b1;
      repeat (2) @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
      chk(wr_en && wr_idx == 5'd8, "R8", "oldest written last", {58'd0, wr_en, wr_idx}, {58'd1, 5'd8});
      repeat (10) @(negedge clk);
      chk(!enq_full, "R8", "slots released after oldest", {63'd0, enq_full}, 64'd0);
      tick = 1'b1;
      repeat (3) @(negedge clk);
      tick = 1'b0;
      repeat (3) @(negedge clk);
      chk(stray_seen == 0, "R3", "refused entry never written", 64'(stray_seen), 64'd0);

      // R1: reset drops pending entries
      enq(5'd20, 8'd2, 64'd20, 1'b1, 1'b0, 6'd0);
      enq(5'd21, 8'd1, 64'd21, 1'b1, 1'b0, 6'd0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      begin
         int seen;
         seen = 0;
         tick = 1'b1;
         for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            if (wr_en) seen++;
         end
         tick = 1'b0;
         chk(seen == 0, "R1", "no write after reset", 64'(seen), 64'd0);
      end
      chk(!enq_full, "R1", "empty after reset", {63'd0, enq_full}, 64'd0);

      chk(err_seen == 0, "R9", "error flag stayed low", 64'(err_seen), 64'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule